// File: doc/BRIEF.md
# Residue Carry-Save Multiply-Accumulate Channel

This block is one lane of a parallel residue-number-system multiply-accumulate engine. Every lane works on a single modulus, fixed by a parameter to one of 32, 31, 29, 27, 25, 23, 19 or 17. Because all of these are at most 32, every residue fits in 5 bits.

On each enabled cycle the lane multiplies a data residue by a coefficient residue modulo m. It then adds the product into an accumulator. The accumulator is not stored as one number: it is a redundant pair of residues whose total is the running value modulo m, so no step inside the loop waits on a full modular resolution of the pair.

The pair is reduced to a single residue only when a read is requested. Signed operands use the complement form: a value -x is carried as m - x. Multiplying and adding these forms directly yields the signed result modulo m. Wraparound of intermediate values is tolerated, and no saturation or scaling takes place in the lane.

Top module: `rns_mac_channel`

## Requirements
- R1: While reset is held (synchronous, active low), and after it is released, the accumulator holds zero, `rd_valid` is 0 and `rd_res` is 0.
- R2: With operand residues below m, a single accumulate into a cleared accumulator leaves a value of (data_res * coef_res) mod m.
- R3: Each cycle with `acc_en` high and `clr` low adds (data_res * coef_res) mod m to the accumulated value, modulo m.
- R4: A cycle with `acc_en` low and `clr` low leaves the accumulated value unchanged, whatever the operand inputs carry.
- R5: A cycle with `clr` high sets the accumulated value to zero, including when `acc_en` is also high in that cycle.
- R6: A cycle with `rd_req` high drives `rd_valid` high one cycle later. At that point `rd_res` equals the accumulated value as it stood before that edge. Without `rd_req`, `rd_valid` falls to 0 and `rd_res` holds.
- R7: Signed operands given in complement form (a negative value -x is applied as (m - x) mod m) accumulate to the signed sum of products reduced into the range 0 to m-1, including when intermediate values wrap.
- R8: Both halves of the stored redundant pair, and `rd_res`, always stay below m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Zero the accumulator; wins over acc_en |
| acc_en | input | 1 | Add the current product into the accumulator |
| data_res | input | 5 | Data residue, below m |
| coef_res | input | 5 | Coefficient residue, below m |
| rd_req | input | 1 | Request a resolved readout |
| rd_valid | output | 1 | Readout present on rd_res this cycle |
| rd_res | output | 5 | Resolved accumulator residue |

## Verification
An accumulate or a clear accepted at a clock edge takes effect in the accumulator at that same edge. A read requested in the next cycle shows the result one edge after the request. Each check therefore drives its inputs 1 ns after an edge, lets the operation and the read request pass through one edge each, and samples `rd_valid` and `rd_res` 1 ns after the read edge. Every product pair for the default modulus 23 is swept exhaustively. Random signed sequences, runs with accumulation disabled, and clears colliding with accumulates are all compared against integer arithmetic reduced modulo 23.

// File: rtl/rns_mac_pkg.sv
// Shared types and modular helpers for the residue MAC lane.
// Assumes every operand passed to the helpers is already below the modulus.
package rns_mac_pkg;
    localparam int RES_W = 5;

    typedef logic [RES_W-1:0] res_t;
    typedef logic [RES_W:0]   mod_t;

    // Redundant accumulator pair: value = (s + c) mod m
    typedef struct packed {
        res_t s;
        res_t c;
    } rpair_t;

    // Modular addition of two residues already below m
    function automatic res_t mod_add(input res_t x, input res_t y, input mod_t m);
        logic [RES_W:0] t;
        t = {1'b0, x} + {1'b0, y};
        if (t >= m) t = t - m;
        return t[RES_W-1:0];
    endfunction

    // Modular doubling of a residue below m
    function automatic res_t mod_dbl(input res_t x, input mod_t m);
        return mod_add(x, x, m);
    endfunction
endpackage

// File: rtl/rns_mulmod_pair.sv
// Modular multiplier that leaves its product as a redundant pair.
// Partial products a*2^j mod m are formed by repeated modular doubling.
// Even-weight terms are folded into the sum half and odd-weight terms into
// the carry half, so each half is a short chain of modular adds.
// Assumes a < MOD and b < MOD.
module rns_mulmod_pair
    import rns_mac_pkg::*;
#(
    parameter int MOD = 23
) (
    input  res_t   a,
    input  res_t   b,
    output rpair_t prod
);
    localparam mod_t M = MOD[RES_W:0];

    res_t pow_r [RES_W];
    res_t pp    [RES_W];

    for (genvar j = 0; j < RES_W; j++) begin : g_pp
        if (j == 0) begin : g_base
            assign pow_r[j] = a;
        end else begin : g_dbl
            assign pow_r[j] = mod_dbl(pow_r[j-1], M);
        end
        assign pp[j] = b[j] ? pow_r[j] : '0;
    end

    // Fold even-weight and odd-weight partial products into the two halves
    always_comb begin
        prod = '0;
        for (int j = 0; j < RES_W; j++) begin
            if ((j % 2) == 0) prod.s = mod_add(prod.s, pp[j], M);
            else              prod.c = mod_add(prod.c, pp[j], M);
        end
    end
endmodule

// File: rtl/rns_pair_merge.sv
// Combines a product pair with the stored accumulator pair into a new
// redundant pair congruent to their total mod MOD. The two halves are
// independent modular adds, so nothing resolves across them here.
// Assumes all inputs are below MOD.
module rns_pair_merge
    import rns_mac_pkg::*;
#(
    parameter int MOD = 23
) (
    input  rpair_t prod,
    input  rpair_t acc,
    output rpair_t nxt
);
    localparam mod_t M = MOD[RES_W:0];

    // Half-by-half modular sum
    always_comb begin
        nxt.s = mod_add(prod.s, acc.s, M);
        nxt.c = mod_add(prod.c, acc.c, M);
    end
endmodule

// File: rtl/rns_resolve.sv
// Collapses the redundant pair to one residue when a read is requested and
// registers it. The result holds until the next request.
// Assumes both pair halves are below MOD. Synchronous active-low reset.
module rns_resolve
    import rns_mac_pkg::*;
#(
    parameter int MOD = 23
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_req,
    input  rpair_t acc,
    output logic   rd_valid,
    output res_t   rd_res
);
    localparam mod_t M = MOD[RES_W:0];

    res_t folded;

    // Final carry resolution of the pair
    always_comb folded = mod_add(acc.s, acc.c, M);

    // Register the readout on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_res   <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_res <= folded;
        end
    end
endmodule

// File: rtl/rns_mac_channel.sv
// One modulus lane of a residue-number-system MAC. Each enabled cycle adds
// (data_res * coef_res) mod MOD into a redundant accumulator pair, and a read
// request yields the resolved residue one cycle later.
// Assumes MOD is one of 32, 31, 29, 27, 25, 23, 19, 17 and operands are
// below MOD. Negative values are supplied in complement form (MOD - x).
// clr wins over acc_en. Synchronous active-low reset.
module rns_mac_channel
    import rns_mac_pkg::*;
#(
    parameter int MOD = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       acc_en,
    input  logic [4:0] data_res,
    input  logic [4:0] coef_res,
    input  logic       rd_req,
    output logic       rd_valid,
    output logic [4:0] rd_res
);
    localparam mod_t M = MOD[RES_W:0];

    rpair_t prod;
    rpair_t acc_q;
    rpair_t acc_d;

    rns_mulmod_pair #(.MOD(MOD)) mul_i (
        .a    (data_res),
        .b    (coef_res),
        .prod (prod)
    );

    rns_pair_merge #(.MOD(MOD)) merge_i (
        .prod (prod),
        .acc  (acc_q),
        .nxt  (acc_d)
    );

    rns_resolve #(.MOD(MOD)) res_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .acc      (acc_q),
        .rd_valid (rd_valid),
        .rd_res   (rd_res)
    );

    // Accumulator pair register: clear first, then gated update
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clr)    acc_q <= '0;
        else if (acc_en) acc_q <= acc_d;
    end

    // R8
    pair_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q.s < M) && (acc_q.c < M));

    // R8
    rd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_res < M);

    // R5
    clr_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0));

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !acc_en) |=> $stable(acc_q));

    // R6
    rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rd_valid && $stable(rd_res)));
endmodule

// File: tb/rns_mac_channel_tb_top.sv
module rns_mac_channel_tb_top;
    localparam int M = 23;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       acc_en = 1'b0;
    logic [4:0] data_res = '0;
    logic [4:0] coef_res = '0;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [4:0] rd_res;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rns_mac_channel #(.MOD(M)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en),
        .data_res(data_res), .coef_res(coef_res), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_res(rd_res)
    );

    function automatic int to_res(input longint v);
        longint r;
        r = v % M;
        if (r < 0) r = r + M;
        return int'(r);
    endfunction

    // One cycle: drive inputs 1 ns after an edge, sample 1 ns after the next
    task automatic cyc(input bit c, input bit e, input int a, input int b, input bit r);
        clr = c; acc_en = e; data_res = 5'(a); coef_res = 5'(b); rd_req = r;
        @(posedge clk); #1;
        clr = 0; acc_en = 0; rd_req = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Read and compare the resolved value
    task automatic read_chk(input string req, input int exp);
        cyc(0, 0, 0, 0, 1);
        check({req, " valid"}, int'(rd_valid), 1);
        check(req, int'(rd_res), exp);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        longint model;
        int held;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs while reset is held
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 rd_res", int'(rd_res), 0);
        rst_n = 1'b1;
        read_chk("R1 acc", 0);

        // R2: exhaustive single products
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                cyc(1, 0, 0, 0, 0);
                cyc(0, 1, a, b, 0);
                read_chk("R2 product", (a * b) % M);
            end
        end

        // R3: running sum of a sweep, read after every step
        cyc(1, 0, 0, 0, 0);
        model = 0;
        for (int a = 0; a < M; a++) begin
            cyc(0, 1, a, (a * 7 + 3) % M, 0);
            model += a * ((a * 7 + 3) % M);
            read_chk("R3 running", to_res(model));
        end

        // R4: disabled cycles with active operands leave the value
        for (int k = 0; k < 5; k++) begin
            cyc(0, 0, M - 1 - k, M - 2, 0);
            read_chk("R4 idle", to_res(model));
        end

        // R5: clear colliding with accumulate
        cyc(1, 1, 9, 11, 0);
        read_chk("R5 clr wins", 0);
        cyc(0, 1, 9, 11, 0);
        cyc(1, 0, 0, 0, 0);
        read_chk("R5 clr alone", 0);

        // R6: rd_res holds and rd_valid drops without a request
        cyc(0, 1, 5, 6, 0);
        read_chk("R6 read", 30 % M);
        held = int'(rd_res);
        cyc(0, 1, 4, 4, 0);
        check("R6 valid low", int'(rd_valid), 0);
        check("R6 hold", int'(rd_res), held);
        // R6: read in the same cycle as an accumulate sees the prior value
        cyc(0, 1, 2, 3, 1);
        check("R6 pre-edge value", int'(rd_res), (30 + 16) % M);
        read_chk("R6 post value", (30 + 16 + 6) % M);

        // R7: random signed sequences in complement form
        for (int s = 0; s < 60; s++) begin
            cyc(1, 0, 0, 0, 0);
            model = 0;
            for (int k = 0; k < 10; k++) begin
                int sa, sb;
                bit en;
                sa = int'($urandom_range(22)) - 11;
                sb = int'($urandom_range(22)) - 11;
                en = ($urandom_range(3) != 0);
                cyc(0, en, to_res(sa), to_res(sb), 0);
                if (en) model += sa * sb;
            end
            read_chk("R7 signed", to_res(model));
        end

        // R7/R8: heavy wraparound with largest residues
        cyc(1, 0, 0, 0, 0);
        model = 0;
        for (int k = 0; k < 40; k++) begin
            cyc(0, 1, M - 1, M - 1, 0);
            model += (M - 1) * (M - 1);
        end
        read_chk("R7 wrap", to_res(model));
        check("R8 range", int'(rd_res < M), 1);

        finish_up();
    end
endmodule